// File: doc/BRIEF.md
# Decimal Up/Down Counter with Preset

This block is a synchronous four-bit counter that walks through the decimal digits 0 to 9 in BCD. A direction input picks up or down counting. An active-low load input copies a four-bit preset into the count on the next clock edge, and an active-low enable either lets the count step or holds it.

A combinational terminal flag reports that the count sits at the end of its range for the current direction. That end is 9 when counting up and 0 when counting down. An active-low ripple output repeats the flag during the low half of the clock, but only while counting is enabled. A following stage can use it as its enable or as its clock. Preset values above 9 are accepted, and the next count step takes the counter back into the decimal range.

Top module: `bcd_updown_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0.
- R2: When load_ni is low at a rising edge, count_o takes preset_i at that edge. This holds whatever the state of cten_ni and down_i.
- R3: When load_ni is high and cten_ni is high at a rising edge, count_o keeps its value.
- R4: When down_i is 0 (up), load_ni is high and cten_ni is low, count_o goes up by one at each rising edge from 0 to 8, and goes from 9 to 0.
- R5: When down_i is 1 (down), load_ni is high and cten_ni is low, count_o goes down by one at each rising edge from 9 to 1, and goes from 0 to 9.
- R6: maxmin_o is 1 exactly when either (down_i is 0 and count_o is 9) or (down_i is 1 and count_o is 0). It follows down_i with no clock delay and does not depend on cten_ni.
- R7: rco_no is 0 only while clk_i is low, maxmin_o is 1 and cten_ni is low. At all other times it is 1.
- R8: From a loaded count of 10 to 15, one enabled up step gives 0 and one enabled down step gives 9. With the enable off, the out-of-range value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Synchronous preset load, active low |
| cten_ni | input | 1 | Count enable, active low |
| down_i | input | 1 | Direction: 0 up, 1 down |
| preset_i | input | 4 | Value to load |
| count_o | output | 4 | BCD count |
| maxmin_o | output | 1 | Terminal count flag for the current direction |
| rco_no | output | 1 | Ripple output, active low, low clock phase only |

## Verification
count_o changes one rising edge after a load, hold or step is applied. Its expected value is therefore queued when the stimulus is driven and compared one nanosecond after the next rising edge. maxmin_o has no registers on its path and follows the count and direction within the same cycle. It is checked during the high phase right after the inputs settle. rco_no is checked twice in every cycle: high during the high phase, and at its expected level one nanosecond after the falling edge.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned CNT_MOD = 10;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/bcd_next_state.sv
module bcd_next_state #(
  parameter int unsigned W   = bcd_cnt_pkg::CNT_W,
  parameter int unsigned MOD = bcd_cnt_pkg::CNT_MOD
) (
  input  logic [W-1:0] cur_i,
  input  logic         load_ni,
  input  logic         cten_ni,
  input  logic         down_i,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);
  localparam logic [W-1:0] ONE  = W'(1);

  bcd_cnt_pkg::dir_e dir;
  assign dir = bcd_cnt_pkg::dir_e'(down_i);

  always_comb begin
    nxt_o = cur_i;
    if (!load_ni) begin
      nxt_o = preset_i;
    end else if (!cten_ni) begin
      unique case (dir)
        bcd_cnt_pkg::DIR_UP:
          // out-of-range values fold to zero in one step
          nxt_o = (cur_i >= LAST) ? '0 : cur_i + ONE;
        bcd_cnt_pkg::DIR_DOWN:
          nxt_o = (cur_i == '0 || cur_i > LAST) ? LAST : cur_i - ONE;
        default: nxt_o = cur_i;
      endcase
    end
  end
endmodule

// File: rtl/bcd_terminal_detect.sv
module bcd_terminal_detect #(
  parameter int unsigned W   = bcd_cnt_pkg::CNT_W,
  parameter int unsigned MOD = bcd_cnt_pkg::CNT_MOD
) (
  input  logic [W-1:0] cur_i,
  input  logic         down_i,
  output logic         at_term_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic at_top, at_bot;
  assign at_top    = (cur_i == LAST);
  assign at_bot    = (cur_i == '0);
  assign at_term_o = down_i ? at_bot : at_top;
endmodule

// File: rtl/bcd_ripple_gate.sv
module bcd_ripple_gate (
  input  logic clk_i,
  input  logic at_term_i,
  input  logic cten_ni,
  output logic rco_no
);
  // pulse only in the low clock phase so a next stage sees a clean edge
  assign rco_no = ~(at_term_i & ~cten_ni & ~clk_i);
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter #(
  parameter int unsigned W   = bcd_cnt_pkg::CNT_W,
  parameter int unsigned MOD = bcd_cnt_pkg::CNT_MOD
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_ni,
  input  logic         cten_ni,
  input  logic         down_i,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] count_o,
  output logic         maxmin_o,
  output logic         rco_no
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_term;

  bcd_next_state #(.W(W), .MOD(MOD)) u_next (
    .cur_i   (cnt_q),
    .load_ni (load_ni),
    .cten_ni (cten_ni),
    .down_i  (down_i),
    .preset_i(preset_i),
    .nxt_o   (cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  bcd_terminal_detect #(.W(W), .MOD(MOD)) u_term (
    .cur_i    (cnt_q),
    .down_i   (down_i),
    .at_term_o(at_term)
  );

  bcd_ripple_gate u_rco (
    .clk_i    (clk_i),
    .at_term_i(at_term),
    .cten_ni  (cten_ni),
    .rco_no   (rco_no)
  );

  assign count_o  = cnt_q;
  assign maxmin_o = at_term;
endmodule

// File: rtl/bcd_updown_counter_chk.sv
module bcd_updown_counter_chk #(
  parameter int unsigned W   = bcd_cnt_pkg::CNT_W,
  parameter int unsigned MOD = bcd_cnt_pkg::CNT_MOD
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_ni,
  input logic         cten_ni,
  input logic         down_i,
  input logic [W-1:0] preset_i,
  input logic [W-1:0] count_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(preset_i));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cten_ni) |=> $stable(count_o));

  assert_up_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !cten_ni && !down_i && count_o == LAST) |=> count_o == '0);

  assert_down_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !cten_ni && down_i && count_o == '0) |=> count_o == LAST);

  assert_recover_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !cten_ni && count_o > LAST) |=>
      count_o == ($past(down_i) ? LAST : '0));
endmodule

bind bcd_updown_counter bcd_updown_counter_chk #(.W(W), .MOD(MOD)) u_chk (.*);

// File: tb/bcd_updown_counter_tb.sv
module bcd_updown_counter_tb;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       load_ni, cten_ni, down_i;
  logic [3:0] preset_i;
  logic [3:0] count_o;
  logic       maxmin_o, rco_no;

  int total = 0;
  int bad   = 0;
  int       exp_q[$];
  string    tag_q[$];
  int       model_cnt = 0;

  always #(CLK_P / 2) clk_i = ~clk_i;

  bcd_updown_counter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_ni(load_ni), .cten_ni(cten_ni),
    .down_i(down_i), .preset_i(preset_i), .count_o(count_o),
    .maxmin_o(maxmin_o), .rco_no(rco_no)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // driver: apply one cycle of stimulus, check combinational outputs, queue next count
  task automatic step(input logic ld_n, input logic en_n, input logic dn,
                      input logic [3:0] pv, input string tag);
    bit exp_mm;
    int nxt;
    @(posedge clk_i); #2;
    load_ni = ld_n; cten_ni = en_n; down_i = dn; preset_i = pv;
    #1;
    exp_mm = (!dn && model_cnt == 9) || (dn && model_cnt == 0);
    chk(maxmin_o == exp_mm, "R6 maxmin", maxmin_o, exp_mm);
    chk(rco_no == 1'b1, "R7 rco high phase", rco_no, 1);
    @(negedge clk_i); #1;
    chk(rco_no == !(exp_mm && !en_n), "R7 rco low phase", rco_no, !(exp_mm && !en_n));
    if (!ld_n)     nxt = pv;
    else if (en_n) nxt = model_cnt;
    else if (!dn)  nxt = (model_cnt >= 9) ? 0 : model_cnt + 1;
    else           nxt = (model_cnt == 0 || model_cnt > 9) ? 9 : model_cnt - 1;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
    model_cnt = nxt;
  endtask

  // monitor: compare count one edge after each stimulus
  initial begin
    forever begin
      @(posedge clk_i); #1;
      if (exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(count_o == 4'(e), t, count_o, e);
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; load_ni = 1'b1; cten_ni = 1'b1; down_i = 1'b0; preset_i = '0;
    #(CLK_P * 2 + 1);
    chk(count_o == 4'd0, "R1 reset", count_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < 12; i++) step(1, 0, 0, 4'd0, "R4 up");
    step(0, 0, 1, 4'd9, "R2 load under enable");
    step(1, 1, 0, 4'd0, "R3 hold at 9 up");
    step(1, 1, 0, 4'd3, "R3 hold ignores preset");
    for (int i = 0; i < 12; i++) step(1, 0, 1, 4'd0, "R5 down");
    step(0, 1, 0, 4'd4, "R2 load with enable off");
    step(1, 0, 1, 4'd0, "R5 down from 4");
    step(0, 0, 0, 4'd12, "R2 load 12");
    step(1, 0, 0, 4'd0, "R8 up from 12");
    step(0, 0, 1, 4'd15, "R2 load 15");
    step(1, 0, 1, 4'd0, "R8 down from 15");
    step(0, 0, 0, 4'd10, "R2 load 10");
    step(1, 1, 1, 4'd0, "R8 hold at 10");
    step(1, 0, 1, 4'd0, "R8 down from 10");
    step(0, 0, 0, 4'd0, "R2 load 0");
    step(1, 1, 0, 4'd0, "R6 hold at 0 up");
    step(1, 1, 1, 4'd0, "R6 hold at 0 down");
    step(1, 0, 1, 4'd0, "R5 wrap 0 to 9");
    step(1, 0, 0, 4'd0, "R4 wrap 9 to 0");
    @(posedge clk_i); #3;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule